// File: doc/BRIEF.md
# Masked-Write Register Bridge

This block sits between a host command path and a bank of byte-wide target registers. A command brings a register address, a 16-bit value word and a direction bit. A read returns the addressed byte. A write is done as a read-modify-write: the upper byte of the value word is a bit mask and the lower byte is the new data. Only the bits that the mask selects change. An all-zero mask leaves the register as it was.

The target space is held inside the block as an array of `2**ADDR_W` bytes, so the bridge can be used and tested without any external target. A small controller runs each command through a fixed sequence of states and blocks new commands until the sequence ends.

The states are IDLE, FETCH, STORE and REPLY, with these transitions:
- IDLE→FETCH when a command is accepted (`cmd_valid` with `cmd_ready`).
- FETCH→REPLY for a read.
- FETCH→STORE for a write.
- STORE→REPLY always.
- REPLY→IDLE always.

Top module: `masked_reg_bridge`

## Requirements
- R1: After a synchronous active-high reset, every target register reads 0x00, `cmd_ready` is 1 and `done` is 0.
- R2: On a read, `done` comes with `rsp_len`=1 and `rd_data` holding the current value of the addressed register.
- R3: On a write, `cmd_value[15:8]` is the mask and `cmd_value[7:0]` is the data. The new register value is (old & ~mask) | (data & mask).
- R4: A write whose mask is 0x00 leaves the addressed register unchanged.
- R5: On a write, `done` comes with `rsp_len`=0 and `rd_data`=0x00, which is a zero-length response.
- R6: `cmd_dir`=1 (device-to-host) selects a read and `cmd_dir`=0 (host-to-device) selects a write.
- R7: `cmd_ready` is low from the cycle after acceptance through the `done` cycle, and high again in the cycle after `done`. A command presented while `cmd_ready` is low is ignored.
- R8: `done` is a one-cycle pulse. It is high in the 2nd cycle after the accepting edge for a read and in the 3rd cycle for a write.
- R9: For a read, the value word has no effect on any register.
- R10: A write changes only the addressed register; other addresses keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Bridge idle and able to accept a command |
| cmd_dir | input | 1 | 1 = read (device-to-host), 0 = write (host-to-device) |
| cmd_addr | input | ADDR_W | Target register address |
| cmd_value | input | 2*DATA_W | Mask in the upper half, data in the lower half |
| done | output | 1 | One-cycle completion pulse |
| rsp_len | output | 1 | Response byte count: 1 for a read, 0 for a write |
| rd_data | output | DATA_W | Read result, valid while `done` is high |

## Verification
The bench uses the default parameters: 8-bit addresses and byte-wide registers. With these values the full 256-entry space is in reach, so the bench drives writes and reads at both ends of it (0x00 and 0xFF) and checks that a neighbouring address keeps its contents. It uses partial masks, a full mask, single-bit masks and the zero mask. It also holds a second command on the port while the bridge is busy to show that this command is ignored.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_STORE = 2'd2,
        ST_REPLY = 2'd3
    } bridge_state_e;

endpackage

// File: rtl/bridge_regs.sv
module bridge_regs #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Registered read port; one write port. Reset clears every entry.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
            rdata_q <= '0;
        end else begin
            if (wr_en) begin
                mem[addr] <= wdata;
            end
            if (rd_en) begin
                rdata_q <= mem[addr];
            end
        end
    end

    // R10: a write and a fetch never overlap in the same cycle
    a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && wr_en));

endmodule

// File: rtl/bridge_merge.sv
module bridge_merge #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] new_val,
    input  logic [DATA_W-1:0] bit_sel,
    output logic [DATA_W-1:0] merged
);
    // Per-bit select; bits with a zero select keep their old value.
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign merged[b] = bit_sel[b] ? new_val[b] : old_val[b];
    end
endmodule

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
    import bridge_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_valid,
    input  logic cmd_dir,
    output logic cmd_ready,
    output logic accept,
    output logic fetch,
    output logic store,
    output logic done,
    output logic is_read
);
    bridge_state_e state_q, state_d;
    logic          dir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                dir_q <= cmd_dir;
            end
        end
    end

    always_comb begin
        state_d   = state_q;
        cmd_ready = 1'b0;
        accept    = 1'b0;
        fetch     = 1'b0;
        store     = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                if (cmd_valid) begin
                    accept  = 1'b1;
                    state_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                fetch   = 1'b1;
                state_d = dir_q ? ST_REPLY : ST_STORE;
            end
            ST_STORE: begin
                store   = 1'b1;
                state_d = ST_REPLY;
            end
            ST_REPLY: begin
                done    = 1'b1;
                state_d = ST_IDLE;
            end
        endcase
    end

    assign is_read = dir_q;

    // R8: completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R8: read completes two cycles after acceptance
    a_r8_read_latency: assert property (@(posedge clk) disable iff (rst)
        (accept && cmd_dir) |=> ##1 done);
    // R8: write completes three cycles after acceptance
    a_r8_write_latency: assert property (@(posedge clk) disable iff (rst)
        (accept && !cmd_dir) |=> ##2 done);
    // R7: ready returns in the cycle after completion
    a_r7_ready_after_done: assert property (@(posedge clk) disable iff (rst)
        done |=> cmd_ready);
    // R7: no acceptance while a command is in flight
    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        accept |=> !cmd_ready);

endmodule

// File: rtl/masked_reg_bridge.sv
module masked_reg_bridge #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_valid,
    output logic                  cmd_ready,
    input  logic                  cmd_dir,
    input  logic [ADDR_W-1:0]     cmd_addr,
    input  logic [2*DATA_W-1:0]   cmd_value,
    output logic                  done,
    output logic                  rsp_len,
    output logic [DATA_W-1:0]     rd_data
);
    localparam int WORD_W = 2 * DATA_W;

    logic              accept, fetch, store, is_read;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] mask_q, wdat_q;
    logic [DATA_W-1:0] old_q, merged;

    // Command capture on acceptance
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            mask_q <= '0;
            wdat_q <= '0;
        end else if (accept) begin
            addr_q <= cmd_addr;
            mask_q <= cmd_value[WORD_W-1:DATA_W];
            wdat_q <= cmd_value[DATA_W-1:0];
        end
    end

    bridge_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_dir   (cmd_dir),
        .cmd_ready (cmd_ready),
        .accept    (accept),
        .fetch     (fetch),
        .store     (store),
        .done      (done),
        .is_read   (is_read)
    );

    bridge_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (fetch),
        .wr_en   (store),
        .addr    (addr_q),
        .wdata   (merged),
        .rdata_q (old_q)
    );

    bridge_merge #(.DATA_W(DATA_W)) u_merge (
        .old_val (old_q),
        .new_val (wdat_q),
        .bit_sel (mask_q),
        .merged  (merged)
    );

    assign rsp_len = done && is_read;
    assign rd_data = (done && is_read) ? old_q : '0;

    // R3: unmasked bits of the written value equal the fetched value
    a_r3_unmasked_kept: assert property (@(posedge clk) disable iff (rst)
        store |-> ((merged ^ old_q) & ~mask_q) == '0);
    // R4: zero mask writes back the fetched value
    a_r4_zero_mask: assert property (@(posedge clk) disable iff (rst)
        (store && mask_q == '0) |-> merged == old_q);
    // R5: write response carries no data
    a_r5_write_empty: assert property (@(posedge clk) disable iff (rst)
        (done && !rsp_len) |-> rd_data == '0);
    // R9: a read never writes the target space
    a_r9_read_no_store: assert property (@(posedge clk) disable iff (rst)
        is_read |-> !store);

endmodule

// File: tb/tb_masked_reg_bridge.sv
module tb_masked_reg_bridge;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic        cmd_ready;
    logic        cmd_dir;
    logic [7:0]  cmd_addr;
    logic [15:0] cmd_value;
    logic        done;
    logic        rsp_len;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #4 clk = ~clk;   // 125 MHz

    masked_reg_bridge dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_dir(cmd_dir), .cmd_addr(cmd_addr), .cmd_value(cmd_value),
        .done(done), .rsp_len(rsp_len), .rd_data(rd_data)
    );

    // {dir, addr, value, expected rd_data}; dir 1 = read
    localparam logic [32:0] VEC [12] = '{
        {1'b0, 8'h10, 16'hFFA5, 8'h00},  // R3 full mask
        {1'b1, 8'h10, 16'h0000, 8'hA5},  // R2
        {1'b0, 8'h10, 16'h0F3C, 8'h00},  // R3 low nibble
        {1'b1, 8'h10, 16'h0000, 8'hAC},
        {1'b0, 8'h10, 16'h00FF, 8'h00},  // R4 zero mask
        {1'b1, 8'h10, 16'h0000, 8'hAC},
        {1'b1, 8'h11, 16'h0000, 8'h00},  // R10 neighbour
        {1'b0, 8'hFF, 16'hF05A, 8'h00},  // R3 top address
        {1'b1, 8'hFF, 16'hFFFF, 8'h50},  // R9 value ignored
        {1'b0, 8'h00, 16'h81FF, 8'h00},  // R3 single bits
        {1'b1, 8'h00, 16'h0000, 8'h81},
        {1'b1, 8'h10, 16'h0000, 8'hAC}   // R10
    };

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual cycle %0d expected under 100000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_cmd(input logic dir, input logic [7:0] addr, input logic [15:0] val,
                          output logic [7:0] data, output logic len, output int lat);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_dir = dir; cmd_addr = addr; cmd_value = val;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_value = 16'hDEAD;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        data = rd_data;
        len  = rsp_len;
        @(negedge clk);
        check("R8 done pulse", {15'd0, done}, 16'd0);
        check("R7 ready after done", {15'd0, cmd_ready}, 16'd1);
    endtask

    initial begin
        logic [7:0] d;
        logic       l;
        int         lat;
        rst = 1'b1; cmd_valid = 1'b0; cmd_dir = 1'b0; cmd_addr = '0; cmd_value = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1 ready after reset", {15'd0, cmd_ready}, 16'd1);
        check("R1 done low after reset", {15'd0, done}, 16'd0);
        do_cmd(1'b1, 8'h42, 16'h0000, d, l, lat);
        check("R1 register zero", {8'd0, d}, 16'h0000);

        for (int i = 0; i < 12; i++) begin
            do_cmd(VEC[i][32], VEC[i][31:24], VEC[i][23:8], d, l, lat);
            if (VEC[i][32]) begin
                check("R2 R6 read data", {8'd0, d}, {8'd0, VEC[i][7:0]});
                check("R2 read length", {15'd0, l}, 16'd1);
                check("R8 read latency", lat[15:0], 16'd2);
            end else begin
                check("R5 write data", {8'd0, d}, 16'h0000);
                check("R5 write length", {15'd0, l}, 16'd0);
                check("R8 write latency", lat[15:0], 16'd3);
            end
        end

        // R7: a command held while busy is ignored
        @(negedge clk);
        cmd_valid = 1'b1; cmd_dir = 1'b0; cmd_addr = 8'h20; cmd_value = 16'hFF11;
        @(negedge clk);
        cmd_value = 16'hFF22;
        while (!done) begin
            check("R7 busy not ready", {15'd0, cmd_ready}, 16'd0);
            @(negedge clk);
        end
        check("R7 busy not ready at done", {15'd0, cmd_ready}, 16'd0);
        cmd_valid = 1'b0;
        do_cmd(1'b1, 8'h20, 16'h0000, d, l, lat);
        check("R7 held command ignored", {8'd0, d}, 16'h0011);

        // R1: reset clears written registers
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        do_cmd(1'b1, 8'h10, 16'h0000, d, l, lat);
        check("R1 cleared by reset", {8'd0, d}, 16'h0000);
        do_cmd(1'b1, 8'hFF, 16'h0000, d, l, lat);
        check("R1 cleared by reset top", {8'd0, d}, 16'h0000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule